// File: doc/BRIEF.md
# Streaming Matrix Transpose Buffer

This block accepts one frame of a matrix as a row-major stream of complex samples, one sample for each cycle in which the input valid is high. Each sample is stored in an internal single-port memory at the position it takes in the transposed matrix. The write address comes from arithmetic on the running sample index. It does not come from a stored address table. When the input valid drops after the frame, the block reads the memory out in plain ascending address order. The output stream is therefore the transposed matrix in row-major order. A start flag marks the first word of the readout.

The matrix has `ROWS` rows and `COLS` columns. The defaults are 32 and 32, which gives 1024 entries and a 10-bit memory address. When both dimensions are powers of two, the index splits into row and column fields by bit slicing, and the address is the concatenation of those fields in swapped order. For other dimensions a constant divide and modulo path is elaborated. Each frame passes through four phases in turn: idle, fill, drain and hold. The block stays in hold until the next reset.

Top module: `tp_transpose_buf`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `out_valid`, `out_sof` and `ovf_err` are 0, and they stay 0 while no input arrives.
- R2: Input sample k, counted from 0, is stored at address (k mod COLS)*ROWS + floor(k / COLS). Output word j therefore equals input sample (j mod ROWS)*COLS + floor(j / ROWS).
- R3: Transposition is correct both for power-of-two dimensions (32x32, bit-slice path) and for other dimensions (3 rows by 5 columns, arithmetic path).
- R4: A data word is 16 bits wide. Bits 15:8 hold the signed imaginary byte and bits 7:0 hold the signed real byte. Both bytes reach the output unchanged.
- R5: The fill phase ends at the first cycle in which `in_valid` is low. The first output word appears two clock cycles after that cycle: one cycle to enter drain and one cycle of memory read latency.
- R6: The drain phase outputs exactly ROWS*COLS words on consecutive cycles. `out_sof` is high with the first word only.
- R7: After the drain the block holds with `out_valid` low and ignores all input until reset.
- R8: Input samples that arrive during the drain phase are ignored, and the output stream is unaffected.
- R9: If more than ROWS*COLS samples arrive in one frame, `ovf_err` goes high and stays high until reset. The surplus samples are discarded. `ovf_err` stays 0 for a frame of exact length.
- R10: A reset in the middle of the fill phase clears the sample index. The next frame is then transposed correctly from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Input sample, {imag[7:0], real[7:0]} |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Transposed output word |
| out_sof | output | 1 | High with the first word of the readout |
| ovf_err | output | 1 | Sticky flag: the frame had too many samples |

## Verification
The hardest condition to reach from the ports is a reset in the middle of the fill phase. In that case the memory keeps its stale contents while the sample index must restart. The bench writes a partial frame, pulses reset, and then sends a full frame whose pattern differs from the stale one. Any index that survives the reset shifts every address and shows up as mismatches across the readout. Overflow gets a similar treatment on a 3-by-5 instance: two extra samples carry values that do not appear in the valid frame, so any one of them that reaches memory is caught.

// File: rtl/tp_pkg.sv
// Package: shared phase encoding for the transpose buffer.
// Assumes: one frame at a time, phases advance strictly in order.
package tp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2,
        PH_HOLD  = 2'd3
    } tp_phase_t;
endpackage

// File: rtl/tp_addr_gen.sv
// Module: tp_addr_gen
// Maps a row-major sample index to its address in the transposed matrix.
// Assumes: idx < ROWS*COLS whenever en is high. Power-of-two dimensions use
// bit slicing only; other dimensions use constant divide/modulo.
module tp_addr_gen #(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    localparam int DEPTH = ROWS * COLS,
    localparam int AW = $clog2(DEPTH),
    localparam int KW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [KW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam bit POW2 = ((ROWS & (ROWS - 1)) == 0) && ((COLS & (COLS - 1)) == 0);

    generate
        if (POW2) begin : g_slice
            localparam int RB = $clog2(ROWS);
            localparam int CB = $clog2(COLS);
            logic unused_idx_msb;
            // Purpose: swap the column and row fields of the index.
            always_comb begin
                addr = {idx[CB-1:0], idx[CB+RB-1:CB]};
                unused_idx_msb = idx[KW-1];
            end
        end else begin : g_arith
            logic [31:0] row_q;
            logic [31:0] col_q;
            logic [31:0] sum_q;
            // Purpose: split the index by constant divide and rebuild it column-major.
            always_comb begin
                row_q = 32'(idx) / 32'(COLS);
                col_q = 32'(idx) % 32'(COLS);
                sum_q = col_q * 32'(ROWS) + row_q;
                addr  = sum_q[AW-1:0];
            end
        end
    endgenerate

    // R2: every address used for a write lies inside the memory
    p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (32'(addr) < 32'(DEPTH)));
endmodule

// File: rtl/tp_mem.sv
// Module: tp_mem
// Single-port memory with one-cycle registered read and a matching valid.
// Assumes: we and re are never high together (one port, one access).
module tp_mem #(
    parameter int DW = 16,
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] store [DEPTH];

    // Purpose: write port and registered read port sharing one address.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        if (re) begin
            rdata <= store[addr];
        end
    end

    // Purpose: delay the read strobe by the read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
        end
    end

    // R5: read data valid follows a read by exactly one cycle
    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> rvalid);
    // R8: the single port is never asked to read and write at once
    p_port_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/tp_ctrl.sv
// Module: tp_ctrl
// Phase sequencer: counts input samples during fill, sweeps read addresses
// during drain, then holds. Flags frames longer than ROWS*COLS.
// Assumes: a frame is a contiguous run of in_valid cycles.
module tp_ctrl
    import tp_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    localparam int DEPTH = ROWS * COLS,
    localparam int AW = $clog2(DEPTH),
    localparam int KW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          wr_en,
    output logic [KW-1:0] wr_idx,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rd_first,
    output logic          ovf_err
);
    tp_phase_t     phase;
    logic [KW-1:0] idx_q;
    logic [AW-1:0] rcnt_q;
    logic          frame_full;

    // Purpose: decide when a frame has no room left.
    always_comb begin
        frame_full = (idx_q == KW'(DEPTH));
    end

    // Purpose: phase transitions, sample index, read counter and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            idx_q   <= '0;
            rcnt_q  <= '0;
            ovf_err <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (in_valid) begin
                        idx_q <= KW'(1);
                        phase <= PH_FILL;
                    end
                end
                PH_FILL: begin
                    if (in_valid) begin
                        if (frame_full) begin
                            ovf_err <= 1'b1;
                        end else begin
                            idx_q <= idx_q + KW'(1);
                        end
                    end else begin
                        phase <= PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    rcnt_q <= rcnt_q + AW'(1);
                    if (rcnt_q == AW'(DEPTH - 1)) begin
                        phase <= PH_HOLD;
                    end
                end
                default: begin
                    phase <= PH_HOLD;
                end
            endcase
        end
    end

    // Purpose: strobes toward address generator and memory.
    always_comb begin
        wr_en    = in_valid && ((phase == PH_IDLE) || ((phase == PH_FILL) && !frame_full));
        wr_idx   = (phase == PH_IDLE) ? '0 : idx_q;
        rd_en    = (phase == PH_DRAIN);
        rd_addr  = rcnt_q;
        rd_first = rd_en && (rcnt_q == '0);
    end

    // R7: once holding, the sequencer never leaves until reset
    p_hold_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> (phase == PH_HOLD));
    // R9: the overflow flag never clears without reset
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
    // R6: read addresses advance by one on consecutive drain cycles
    p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr != '0)) |-> (rd_addr == $past(rd_addr) + AW'(1)));
    // R9: no write once the frame is full
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_full |-> !wr_en);
endmodule

// File: rtl/tp_transpose_buf.sv
// Module: tp_transpose_buf (top)
// Scatter-writes a row-major complex frame at transposed addresses, then
// streams the memory out linearly with a start-of-readout flag.
// Assumes: ROWS, COLS >= 2; data word is {imag[7:0], real[7:0]}.
module tp_transpose_buf #(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sof,
    output logic          ovf_err
);
    localparam int DEPTH = ROWS * COLS;
    localparam int AW = $clog2(DEPTH);
    localparam int KW = $clog2(DEPTH + 1);

    logic          wr_en;
    logic [KW-1:0] wr_idx;
    logic [AW-1:0] wr_addr;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          rd_first;
    logic [AW-1:0] mem_addr;
    logic          sof_q;

    tp_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_first (rd_first),
        .ovf_err  (ovf_err)
    );

    tp_addr_gen #(.ROWS(ROWS), .COLS(COLS)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wr_en),
        .idx   (wr_idx),
        .addr  (wr_addr)
    );

    // Purpose: pick the single memory address for the active phase.
    always_comb begin
        mem_addr = wr_en ? wr_addr : rd_addr;
    end

    tp_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .re     (rd_en),
        .addr   (mem_addr),
        .wdata  (in_data),
        .rdata  (out_data),
        .rvalid (out_valid)
    );

    // Purpose: align the start flag with the first read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_q <= 1'b0;
        end else begin
            sof_q <= rd_first;
        end
    end

    always_comb begin
        out_sof = sof_q;
    end

    // R6: the start flag only accompanies a valid word
    p_sof_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
    // R6: two start flags never come back to back
    p_sof_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof);
endmodule

// File: tb/tp_transpose_buf_tb.sv
`timescale 1ns/1ps
module tp_transpose_buf_tb;
    localparam int AR = 32, AC = 32;
    localparam int BR = 3,  BC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_vld = 1'b0, b_vld = 1'b0;
    logic [15:0] a_dat = '0, b_dat = '0;
    logic a_ov, b_ov, a_sof, b_sof, a_err, b_err;
    logic [15:0] a_od, b_od;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tp_transpose_buf #(.ROWS(AR), .COLS(AC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(a_vld), .in_data(a_dat),
        .out_valid(a_ov), .out_data(a_od), .out_sof(a_sof), .ovf_err(a_err));

    tp_transpose_buf #(.ROWS(BR), .COLS(BC)) u_dut_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(b_vld), .in_data(b_dat),
        .out_valid(b_ov), .out_data(b_od), .out_sof(b_sof), .ovf_err(b_err));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample word for index i: low byte = column+1 (real), high byte distinct (imag).
    function automatic logic [15:0] pat(input int i, input int cols, input int salt);
        logic [7:0] re_b, im_b;
        re_b = 8'((i % cols) + 1);
        im_b = 8'(i * 7 + 3 + salt);
        return {im_b, re_b};
    endfunction

    task automatic drive(input int sel, input logic v, input logic [15:0] d);
        if (sel == 0) begin a_vld = v; a_dat = d; end
        else begin b_vld = v; b_dat = d; end
    endtask

    function automatic logic get_ov(input int sel);
        return (sel == 0) ? a_ov : b_ov;
    endfunction

    function automatic logic get_sof(input int sel);
        return (sel == 0) ? a_sof : b_sof;
    endfunction

    function automatic logic [15:0] get_od(input int sel);
        return (sel == 0) ? a_od : b_od;
    endfunction

    function automatic logic get_err(input int sel);
        return (sel == 0) ? a_err : b_err;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_vld = 1'b0; b_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Send one frame (plus extra samples), then check the whole readout.
    task automatic run_frame(input int sel, input int extra, input bit junk, input int salt, input string req);
        int rows, cols, depth, wait_n, src;
        logic [15:0] ex;
        rows  = (sel == 0) ? AR : BR;
        cols  = (sel == 0) ? AC : BC;
        depth = rows * cols;
        for (int i = 0; i < depth + extra; i++) begin
            @(negedge clk);
            drive(sel, 1'b1, (i < depth) ? pat(i, cols, salt) : 16'hDEAD);
        end
        @(negedge clk);
        drive(sel, 1'b0, 16'h0);
        wait_n = 0;
        do begin
            @(negedge clk);
            wait_n++;
        end while (!get_ov(sel) && wait_n < 10);
        chk(wait_n == 2, "R5 readout latency", wait_n, 2);
        for (int j = 0; j < depth; j++) begin
            src = (j % rows) * cols + (j / rows);
            ex = pat(src, cols, salt);
            chk(get_ov(sel) == 1'b1, {req, " R6 valid run"}, int'(get_ov(sel)), 1);
            chk(get_od(sel) == ex, {req, " R2 word"}, int'(get_od(sel)), int'(ex));
            chk(get_sof(sel) == (j == 0), "R6 sof", int'(get_sof(sel)), int'(j == 0));
            if (junk) drive(sel, 1'b1, 16'hBEEF);
            @(negedge clk);
        end
        for (int t = 0; t < 12; t++) begin
            if (junk) drive(sel, 1'b1, 16'hF00D);
            chk(get_ov(sel) == 1'b0, "R7 hold silent", int'(get_ov(sel)), 0);
            @(negedge clk);
        end
        drive(sel, 1'b0, 16'h0);
        chk(get_err(sel) == (extra > 0), "R9 ovf flag", int'(get_err(sel)), int'(extra > 0));
    endtask

    task automatic t_reset_state();
        do_reset();
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            chk(!a_ov && !a_sof && !a_err, "R1 idle outputs", int'({a_ov, a_sof, a_err}), 0);
            chk(!b_ov && !b_sof && !b_err, "R1 idle outputs odd", int'({b_ov, b_sof, b_err}), 0);
        end
    endtask

    task automatic t_pow2_frame();
        do_reset();
        run_frame(0, 0, 1'b0, 0, "R3 R4 pow2");
    endtask

    task automatic t_odd_frame();
        do_reset();
        run_frame(1, 0, 1'b0, 5, "R3 odd dims");
    endtask

    task automatic t_junk_in_read();
        do_reset();
        run_frame(0, 0, 1'b1, 11, "R8 junk during drain");
    endtask

    task automatic t_overflow();
        do_reset();
        run_frame(1, 2, 1'b0, 9, "R9 overflow");
    endtask

    task automatic t_mid_reset();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            drive(0, 1'b1, pat(i, AC, 77));
        end
        @(negedge clk);
        rst_n = 1'b0;
        a_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!a_ov && !a_err, "R10 reset in fill", int'({a_ov, a_err}), 0);
        rst_n = 1'b1;
        run_frame(0, 0, 1'b0, 33, "R10 after mid reset");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_pow2_frame();
        t_odd_frame();
        t_junk_in_read();
        t_overflow();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule